// File: doc/BRIEF.md
# Fibonacci Term Generator

This block computes one Fibonacci term from a requested index. A small controller steps through three states: waiting, computing and finished. It drives a single enable into a datapath that holds the two most recent terms and advances them by one term on every clock. When the run ends, a separate output register captures the requested term and keeps it until a later run finishes.

The user sets `num_terms` to the index wanted and pulls `start_n` low. `done` falls for the length of the computation and rises again when `result` holds fib(`num_terms`), where fib(0)=0, fib(1)=1 and each later term is the sum of the two before it. `start_n` must return high before another run can begin. The largest index is the parameter `MAX_TERMS`. The widths of the count input and of the value are derived from it.

Top module: `fib_fsmd`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is in the waiting state, with `done` = 1 and `result` = 0.
- R2: In the waiting state, `start_n` = 0 at a rising edge moves the block to the computing state at that edge, and `done` reads 0 after that edge.
- R3: `done` is 1 in the waiting and finished states and 0 only in the computing state. For an index N in 1..`MAX_TERMS`, the computing state lasts exactly N cycles.
- R4: The index is loaded into a down-counter on every waiting cycle. The counter decrements on each computing cycle, and computing ends on the cycle in which the counter reads 1 (or 0).
- R5: After a run with index N in 1..`MAX_TERMS`, `result` = fib(N). For example, N=1 gives 1, N=2 gives 1, N=6 gives 8, and N=`MAX_TERMS`=24 gives 46368.
- R6: An index of 0 produces `result` = 0 after a single computing cycle.
- R7: An index greater than `MAX_TERMS` is treated as `MAX_TERMS`, both for the result and for the run length.
- R8: In the finished state, the block stays finished while `start_n` stays 0. It returns to waiting at the first edge with `start_n` = 1. A new run needs `start_n` to go low again.
- R9: `result` changes only at the edge that ends a run. Changes to `num_terms` during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Start request, active low |
| num_terms | input | $clog2(MAX_TERMS+1) | Index of the term to compute |
| done | output | 1 | High when idle or finished, low while computing |
| result | output | width of fib(MAX_TERMS) | Most recently computed term |

## Verification
A wrong state or counter value shows at the ports as a `done` low period whose length differs from the requested index. The bench measures that length cycle by cycle. A bad datapath register, or a counter that starts from a stale value, shows as a wrong `result` when `done` rises. The bench sees that within the same run. A finished state that does not wait for `start_n` to go high shows as `done` falling again within one cycle of completion while the start input is held low.

// File: rtl/fib_pkg.sv
package fib_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_CALC = 2'd1,
    ST_FIN  = 2'd2
  } fib_state_e;

  // Number of bits needed to hold fib(terms).
  function automatic int fib_width(input int terms);
    longint a;
    longint b;
    longint t;
    int     w;
    a = 0;
    b = 1;
    for (int i = 0; i < terms; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    w = 0;
    for (int k = 1; k < 63; k++) begin
      if (w == 0 && (longint'(1) <<< k) > a) w = k;
    end
    return w;
  endfunction

endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
#(
  parameter int MAX_TERMS = 24,
  parameter int CW        = $clog2(MAX_TERMS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  input  logic [CW-1:0] num_terms,
  output logic          calc,
  output logic          capture,
  output logic          zero_len,
  output logic          done
);

  localparam logic [CW-1:0] LIMIT = CW'(MAX_TERMS);
  localparam logic [CW-1:0] ONE   = CW'(1);

  fib_state_e    state;
  logic [CW-1:0] remain;
  logic [CW-1:0] load_val;
  logic          last_step;

  assign load_val  = (num_terms > LIMIT) ? LIMIT : num_terms;
  assign last_step = (remain <= ONE);
  assign calc      = (state == ST_CALC);
  assign capture   = calc && last_step;
  assign zero_len  = (remain == '0);
  assign done      = !calc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_WAIT;
      remain <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          remain <= load_val;
          if (!start_n) state <= ST_CALC;
        end
        ST_CALC: begin
          remain <= remain - ONE;
          if (last_step) state <= ST_FIN;
        end
        ST_FIN: begin
          if (start_n) state <= ST_WAIT;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !start_n) |=> (state == ST_CALC));

  p_exit_at_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CALC && remain == ONE) |=> (state == ST_FIN));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CALC && remain > ONE) |=>
      (state == ST_CALC && remain == $past(remain) - ONE));

  p_hold_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN && !start_n) |=> (state == ST_FIN));

  p_load_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |=> (remain <= LIMIT));

endmodule

// File: rtl/fib_datapath.sv
module fib_datapath #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          calc,
  output logic [VW-1:0] newer,
  output logic [VW-1:0] older
);

  // Next term; wraps past VW bits (only on the step after the captured one).
  function automatic logic [VW-1:0] next_term(input logic [VW-1:0] a,
                                              input logic [VW-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older <= '0;
      newer <= VW'(1);
    end else if (!calc) begin
      older <= '0;
      newer <= VW'(1);
    end else begin
      older <= newer;
      newer <= next_term(newer, older);
    end
  end

  p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !calc |=> (older == '0 && newer == VW'(1)));

  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    calc |=> (older == $past(newer)));

endmodule

// File: rtl/fib_out_reg.sv
module fib_out_reg #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          zero_len,
  input  logic [VW-1:0] newer,
  output logic [VW-1:0] result
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= '0;
    else if (capture) result <= zero_len ? '0 : newer;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result));

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && zero_len) |=> (result == '0));

endmodule

// File: rtl/fib_fsmd.sv
module fib_fsmd
  import fib_pkg::*;
#(
  parameter int MAX_TERMS = 24,
  parameter int CW        = $clog2(MAX_TERMS + 1),
  parameter int VW        = fib_width(MAX_TERMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  input  logic [CW-1:0] num_terms,
  output logic          done,
  output logic [VW-1:0] result
);

  logic          calc;
  logic          capture;
  logic          zero_len;
  logic [VW-1:0] newer;
  logic [VW-1:0] older;

  fib_ctrl #(.MAX_TERMS(MAX_TERMS), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .num_terms(num_terms),
    .calc(calc), .capture(capture), .zero_len(zero_len), .done(done)
  );

  fib_datapath #(.VW(VW)) u_dp (
    .clk(clk), .rst_n(rst_n), .calc(calc), .newer(newer), .older(older)
  );

  fib_out_reg #(.VW(VW)) u_out (
    .clk(clk), .rst_n(rst_n), .capture(capture), .zero_len(zero_len),
    .newer(newer), .result(result)
  );

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (done && result == '0));

  p_done_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |=> !$stable(older) || !done || (older == newer));

endmodule

// File: tb/fib_fsmd_bench.sv
module fib_fsmd_bench;

  localparam int MAXT = 24;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int VW   = fib_pkg::fib_width(MAXT);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_n = 1'b1;
  logic [CW-1:0] num_terms = '0;
  logic          done;
  logic [VW-1:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fib_fsmd #(.MAX_TERMS(MAXT)) u_fib_fsmd (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .num_terms(num_terms),
    .done(done), .result(result)
  );

  // Reference term, computed by repeated pair update.
  function automatic longint ref_fib(input int n);
    longint p = 0;
    longint q = 1;
    longint s;
    for (int i = 0; i < n; i++) begin
      s = p + q; p = q; q = s;
    end
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Launch a run, measure the done-low period, check the term.
  task automatic t_run(input int n, input int exp_len, input longint exp_val);
    int len = 0;
    @(negedge clk);
    num_terms = CW'(n);
    start_n = 1'b0;
    chk(done == 1'b1, "R3 done high while waiting", longint'(done), 1);
    @(posedge clk);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done) break;
      len++;
    end
    chk(len == exp_len, "R3/R4 run length", len, exp_len);
    chk(longint'(result) == exp_val, "R5 result value", longint'(result), exp_val);
    // R8: held start keeps the block finished
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b1, "R8 finished while start held", longint'(done), 1);
    end
    start_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(done == 1'b1 && longint'(result) == exp_val, "R9 result held after run",
          longint'(result), exp_val);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && result == '0, "R1 reset state", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b1 && result == '0, "R1 after release", longint'(result), 0);
  endtask

  task automatic t_first_edge();
    @(negedge clk);
    num_terms = CW'(5);
    start_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R2 done low one edge after start", longint'(done), 0);
    start_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(longint'(result) == ref_fib(5), "R2 run completes", longint'(result), ref_fib(5));
  endtask

  task automatic t_midrun_change();
    int len = 0;
    @(negedge clk);
    num_terms = CW'(10);
    start_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    len++;
    num_terms = CW'(3);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done) break;
      len++;
    end
    chk(len == 10, "R9 mid-run index change ignored (length)", len, 10);
    chk(longint'(result) == ref_fib(10), "R9 mid-run index change ignored (value)",
        longint'(result), ref_fib(10));
    start_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_first_edge();
    t_run(6, 6, 8);
    t_run(1, 1, 1);
    t_run(2, 2, 1);
    t_run(9, 9, ref_fib(9));
    t_run(0, 1, 0);                 // R6
    t_run(MAXT, MAXT, ref_fib(MAXT));
    t_run(31, MAXT, ref_fib(MAXT)); // R7
    t_midrun_change();
    t_run(3, 3, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule